// File: doc/BRIEF.md
# Ethernet Transmit Chain Sequencer

This block runs a linked chain of transmit frame descriptors held in local memory. A host writes the address of the first descriptor, sets two configuration bits and pulses `start`. The sequencer reads each descriptor (frame length, next-descriptor address, end-of-chain flag). It hands the frame's base address and length to the MAC with a one-cycle request, then waits for the MAC's completion and per-attempt status.

When an attempt collides, the sequencer sends the same frame again at the same base address, with no host involvement. It does this for up to 15 retries after the first collision. A 16th collision is an excess-collision error. The current-address register moves to the next descriptor only once a frame is finished, so a retry never resends an earlier frame. Underrun and lost carrier are also errors. Depending on `cfg_stop_on_err`, an error either aborts the chain or is logged before the sequencer moves on.

Interrupts are raised either after every finished frame or once at the end of the chain. Errored frames always interrupt. A status word holds the last frame's error code and retry count, and whether the chain ended normally or was aborted. The `stat_rd` strobe clears the interrupt.

Top module: `tx_chain_seq`

## Requirements
- R1: After reset, `busy`, `irq`, `tx_req` and `desc_req` are 0.
- R2: A `start` pulse while idle fetches the descriptor at `first_addr`. It then pulses `tx_req` with `tx_addr` equal to that descriptor address and `tx_len` equal to the returned length.
- R3: A MAC status of 01 (collision) makes the sequencer resend the same frame at the same `tx_addr`. It does this for at most 15 retries. `stat_coll` reports the number of retries the frame needed.
- R4: A collision on the 16th attempt ends the frame with `stat_err` = 1 (excess collisions) and `stat_coll` = 15.
- R5: A finished frame that is not the last moves `tx_addr` to the descriptor's next address. A retry never resends an earlier frame of the chain.
- R6: With `cfg_irq_per_frame` = 1, `irq` is raised after every finished frame. With 0, an error-free chain raises `irq` exactly once, at its end.
- R7: An errored frame always raises `irq`, whatever the interrupt mode. The `stat_err` codes are: 0 for ok, 1 for excess collisions, 2 for underrun (MAC status 10) and 3 for lost carrier (MAC status 11).
- R8: With `cfg_stop_on_err` = 1, an errored frame ends the chain with `stat_aborted` = 1, and no later frame is requested.
- R9: With `cfg_stop_on_err` = 0, an errored frame is recorded and the next descriptor is still processed.
- R10: `irq` stays high until `stat_rd` is pulsed, and then falls.
- R11: A `start` pulse while `busy` is high is ignored.
- R12: After the frame whose end-of-chain flag is set, `busy` falls and `stat_done` = 1 with `stat_aborted` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse for a chain |
| first_addr | input | 16 | Address of the first descriptor |
| cfg_irq_per_frame | input | 1 | 1: interrupt per frame, 0: per chain |
| cfg_stop_on_err | input | 1 | Abort the chain on an errored frame |
| stat_rd | input | 1 | Status read strobe, clears irq |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | 16 | Descriptor address being fetched |
| desc_valid | input | 1 | Descriptor data valid |
| desc_len | input | 11 | Frame length |
| desc_next | input | 16 | Next descriptor address |
| desc_last | input | 1 | End-of-chain flag |
| tx_req | output | 1 | One-cycle transmit request to the MAC |
| tx_addr | output | 16 | Frame base address |
| tx_len | output | 11 | Frame length |
| tx_done | input | 1 | Attempt complete |
| tx_status | input | 2 | 00 ok, 01 collision, 10 underrun, 11 lost carrier |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | Interrupt to host |
| stat_err | output | 2 | Last frame's error code |
| stat_coll | output | 4 | Last frame's retry count |
| stat_aborted | output | 1 | Chain was aborted |
| stat_done | output | 1 | Chain has ended |

## Verification
The hardest case to reach is the retry limit. It needs sixteen back-to-back collisions on one frame, and the retry counter must saturate exactly at 15 rather than wrapping. The bench's MAC model plays a per-attempt status script. In that script, one frame's sixteen attempts all return collision. The bench then checks that every attempt used the same address and that no later frame was requested. A second case is an error followed by a normal chain end. In chain-interrupt mode this must give two distinct interrupts, so the bench acknowledges each interrupt automatically and counts the rising edges.

// File: rtl/tx_chain_seq.sv
module tx_chain_seq #(
  parameter int AW = 16,
  parameter int LW = 11,
  parameter int MAX_RETRY = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic          cfg_irq_per_frame,
  input  logic          cfg_stop_on_err,
  input  logic          stat_rd,
  output logic          desc_req,
  output logic [AW-1:0] desc_addr,
  input  logic          desc_valid,
  input  logic [LW-1:0] desc_len,
  input  logic [AW-1:0] desc_next,
  input  logic          desc_last,
  output logic          tx_req,
  output logic [AW-1:0] tx_addr,
  output logic [LW-1:0] tx_len,
  input  logic          tx_done,
  input  logic [1:0]    tx_status,
  output logic          busy,
  output logic          irq,
  output logic [1:0]    stat_err,
  output logic [$clog2(MAX_RETRY+1)-1:0] stat_coll,
  output logic          stat_aborted,
  output logic          stat_done
);
  localparam int CW = $clog2(MAX_RETRY + 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SEND, S_WAIT, S_EVAL, S_DONE} state_t;
  state_t state;

  logic [AW-1:0] cur_addr, f_next;
  logic [LW-1:0] f_len;
  logic          f_last;
  logic [1:0]    att_st;
  logic [CW-1:0] retries;

  wire is_coll = (att_st == 2'b01);
  wire excess  = is_coll && (retries == CW'(MAX_RETRY));
  wire retry   = is_coll && !excess;
  wire is_err  = excess || att_st[1];
  wire [1:0] err_code = excess ? 2'd1 : (att_st[1] ? att_st : 2'd0);

  wire irq_set = (state == S_EVAL && !retry && (is_err || cfg_irq_per_frame)) ||
                 (state == S_DONE && !cfg_irq_per_frame && !stat_aborted);

  assign busy      = (state != S_IDLE);
  assign desc_req  = (state == S_FETCH);
  assign desc_addr = cur_addr;
  assign tx_req    = (state == S_SEND);
  assign tx_addr   = cur_addr;
  assign tx_len    = f_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cur_addr     <= '0;
      f_next       <= '0;
      f_len        <= '0;
      f_last       <= 1'b0;
      att_st       <= 2'b00;
      retries      <= '0;
      stat_err     <= 2'd0;
      stat_coll    <= '0;
      stat_aborted <= 1'b0;
      stat_done    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          cur_addr     <= first_addr;
          stat_aborted <= 1'b0;
          stat_done    <= 1'b0;
          state        <= S_FETCH;
        end
        S_FETCH: if (desc_valid) begin
          f_len   <= desc_len;
          f_next  <= desc_next;
          f_last  <= desc_last;
          retries <= '0;
          state   <= S_SEND;
        end
        S_SEND: state <= S_WAIT;
        S_WAIT: if (tx_done) begin
          att_st <= tx_status;
          state  <= S_EVAL;
        end
        S_EVAL: begin
          if (retry) begin
            retries <= retries + 1'b1;
            state   <= S_SEND;
          end else begin
            stat_err  <= err_code;
            stat_coll <= retries;
            if (is_err && cfg_stop_on_err) begin
              stat_aborted <= 1'b1;
              state        <= S_DONE;
            end else if (f_last) begin
              state <= S_DONE;
            end else begin
              cur_addr <= f_next;
              state    <= S_FETCH;
            end
          end
        end
        S_DONE: begin
          stat_done <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (stat_rd) irq <= 1'b0;
  end

  a_r3_retry_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && retry) |=> (state == S_SEND && $stable(cur_addr)));

  a_r4_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && is_coll && retries == CW'(MAX_RETRY)) |=> (stat_err == 2'd1 && state != S_SEND));

  a_r7_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && is_err) |=> irq);

  a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && is_err && cfg_stop_on_err) |=> (state == S_DONE && stat_aborted));

  a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_set) |=> !irq);

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != S_EVAL) |=> $stable(cur_addr));

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE) |=> (!busy && stat_done));
endmodule

// File: tb/test_tx_chain_seq.sv
module test_tx_chain_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 11;

  logic clk = 0, rst_n = 0, start = 0, stat_rd = 0;
  logic [AW-1:0] first_addr = '0;
  logic cfg_irq_per_frame = 0, cfg_stop_on_err = 0;
  logic desc_req, desc_valid, desc_last, tx_req, busy, irq, stat_aborted, stat_done;
  logic [AW-1:0] desc_addr, desc_next, tx_addr;
  logic [LW-1:0] desc_len, tx_len;
  logic tx_done = 0;
  logic [1:0] tx_status = 0, stat_err;
  logic [3:0] stat_coll;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] last_addr = '0;
  logic [1:0] plan_st [0:63];
  logic [AW-1:0] att_addr [0:63];
  logic [LW-1:0] att_len [0:63];
  int n_att = 0, mwait = 0, n_irq = 0;
  logic irq_q = 0, auto_ack = 1;
  logic [1:0] snap_err;
  logic [3:0] snap_coll;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_chain_seq i_tx_chain_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .cfg_irq_per_frame(cfg_irq_per_frame), .cfg_stop_on_err(cfg_stop_on_err),
    .stat_rd(stat_rd), .desc_req(desc_req), .desc_addr(desc_addr),
    .desc_valid(desc_valid), .desc_len(desc_len), .desc_next(desc_next),
    .desc_last(desc_last), .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len),
    .tx_done(tx_done), .tx_status(tx_status), .busy(busy), .irq(irq),
    .stat_err(stat_err), .stat_coll(stat_coll), .stat_aborted(stat_aborted),
    .stat_done(stat_done));

  assign desc_valid = desc_req;
  assign desc_len   = LW'(desc_addr + 16'd5);
  assign desc_next  = desc_addr + 16'h0010;
  assign desc_last  = (desc_addr == last_addr);

  always @(negedge clk) begin
    if (!rst_n) begin
      mwait = 0; tx_done = 0;
    end else if (tx_req) begin
      if (n_att < 64) begin att_addr[n_att] = tx_addr; att_len[n_att] = tx_len; end
      n_att = n_att + 1; mwait = 3; tx_done = 0;
    end else if (mwait == 1) begin
      tx_done = 1; tx_status = plan_st[(n_att - 1) % 64]; mwait = 0;
    end else begin
      tx_done = 0;
      if (mwait > 0) mwait = mwait - 1;
    end
  end

  always @(negedge clk) begin
    if (irq && !irq_q) begin
      n_irq = n_irq + 1; snap_err = stat_err; snap_coll = stat_coll;
    end
    irq_q = irq;
    if (auto_ack) stat_rd = irq;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_chain(input logic [AW-1:0] fa, input logic [AW-1:0] la,
                           input logic per, input logic stop);
    n_att = 0; n_irq = 0;
    first_addr = fa; last_addr = la;
    cfg_irq_per_frame = per; cfg_stop_on_err = stop;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_plan();
    for (int i = 0; i < 64; i++) plan_st[i] = 2'b00;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_req", tx_req, 0);
    chk("R1 desc_req", desc_req, 0);
  endtask

  task automatic t_basic_chain();
    clear_plan();
    run_chain(16'h0010, 16'h0030, 0, 0);
    chk("R2 attempts", n_att, 3);
    chk("R2 first addr", att_addr[0], 16'h0010);
    chk("R2 first len", att_len[0], 11'h015);
    chk("R5 second addr", att_addr[1], 16'h0020);
    chk("R5 third addr", att_addr[2], 16'h0030);
    chk("R6 chain irq count", n_irq, 1);
    chk("R12 busy low", busy, 0);
    chk("R12 done", stat_done, 1);
    chk("R12 not aborted", stat_aborted, 0);
  endtask

  task automatic t_per_frame();
    clear_plan();
    run_chain(16'h0100, 16'h0120, 1, 0);
    chk("R6 per-frame irq count", n_irq, 3);
    chk("R6 last err", snap_err, 0);
  endtask

  task automatic t_collisions();
    clear_plan();
    plan_st[1] = 2'b01; plan_st[2] = 2'b01; plan_st[3] = 2'b01;
    run_chain(16'h0010, 16'h0030, 1, 0);
    chk("R3 attempts", n_att, 6);
    chk("R3 retry addr a", att_addr[2], 16'h0020);
    chk("R3 retry addr b", att_addr[4], 16'h0020);
    chk("R5 after retry", att_addr[5], 16'h0030);
    chk("R3 irq count", n_irq, 3);
    chk("R3 final coll", stat_coll, 0);
  endtask

  task automatic t_coll_snapshot();
    clear_plan();
    plan_st[0] = 2'b01; plan_st[1] = 2'b01; plan_st[2] = 2'b01;
    run_chain(16'h0040, 16'h0040, 0, 0);
    chk("R3 coll count", stat_coll, 3);
    chk("R3 ok after coll", stat_err, 0);
  endtask

  task automatic t_excess();
    clear_plan();
    for (int i = 1; i <= 16; i++) plan_st[i] = 2'b01;
    run_chain(16'h0010, 16'h0030, 0, 1);
    chk("R4 attempts", n_att, 17);
    chk("R4 same addr first", att_addr[1], 16'h0020);
    chk("R4 same addr last", att_addr[16], 16'h0020);
    chk("R4 err code", stat_err, 1);
    chk("R4 coll sat", stat_coll, 15);
    chk("R8 aborted", stat_aborted, 1);
    chk("R7 err irq in chain mode", n_irq, 1);
  endtask

  task automatic t_underrun_continue();
    clear_plan();
    plan_st[0] = 2'b10;
    run_chain(16'h0010, 16'h0030, 0, 0);
    chk("R9 attempts", n_att, 3);
    chk("R9 continues addr", att_addr[1], 16'h0020);
    chk("R7 underrun irq", n_irq, 2);
    chk("R9 not aborted", stat_aborted, 0);
    chk("R9 final err", stat_err, 0);
  endtask

  task automatic t_underrun_code();
    clear_plan();
    plan_st[0] = 2'b10;
    run_chain(16'h0010, 16'h0030, 0, 1);
    chk("R7 underrun code", stat_err, 2);
    chk("R8 underrun stops", n_att, 1);
  endtask

  task automatic t_lost_carrier();
    clear_plan();
    plan_st[1] = 2'b11;
    run_chain(16'h0200, 16'h0240, 0, 1);
    chk("R8 attempts", n_att, 2);
    chk("R7 lost carrier code", stat_err, 3);
    chk("R8 aborted", stat_aborted, 1);
    chk("R7 irq", n_irq, 1);
  endtask

  task automatic t_irq_hold();
    clear_plan();
    auto_ack = 0; stat_rd = 0;
    run_chain(16'h0010, 16'h0010, 0, 0);
    repeat (5) @(negedge clk);
    chk("R10 irq held", irq, 1);
    stat_rd = 1; @(negedge clk); stat_rd = 0; @(negedge clk);
    chk("R10 irq cleared", irq, 0);
    auto_ack = 1;
  endtask

  task automatic t_start_busy();
    clear_plan();
    n_att = 0; n_irq = 0;
    first_addr = 16'h0010; last_addr = 16'h0030;
    cfg_irq_per_frame = 0; cfg_stop_on_err = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (7) @(negedge clk);
    first_addr = 16'h0800; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11 attempts", n_att, 3);
    chk("R11 addr kept", att_addr[1], 16'h0020);
    chk("R11 last addr", att_addr[2], 16'h0030);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    clear_plan();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_basic_chain();
    t_per_frame();
    t_collisions();
    t_coll_snapshot();
    t_excess();
    t_underrun_continue();
    t_underrun_code();
    t_lost_carrier();
    t_irq_hold();
    t_start_busy();
    finish_tb();
  end
endmodule